// File: doc/BRIEF.md
# Decimating Boxcar Averager

This block turns a stream of modulator samples into one 16-bit average per conversion stage. A pulse on `stage_start` clears the running sum and arms the block. After that, every cycle with `smp_stb` high adds `smp_data` to the sum. When the number of accepted samples reaches the stage length, the sum is scaled to the full 16-bit code range and presented with a one-cycle valid pulse.

The stage length is three times a nominal ratio that `ratio_sel` selects. Because that count is not a power of two, scaling uses a fixed-point reciprocal multiply with rounding and saturation instead of a shift. The ratio is sampled only when a stage starts.

With a 1-bit modulator at 250 kHz, the three stage lengths give one result every 3.072, 1.536 or 0.768 ms. A sensor at rest should read near midscale, around 32,700.

Top module: `dec_boxcar_avg`

## Requirements
- R1: While `rst` is held and after it is released, `avg_valid` is 0 and `avg_out` is 0 until the first result.
- R2: `ratio_sel` selects the number of accepted samples per stage: code 2'b00 gives 768 samples, 2'b01 gives 384, and 2'b10 and 2'b11 both give 192. Cycles with `smp_stb` low are not counted.
- R3: For a stage of N samples with sum S, with M = 2^SAMPLE_W - 1 and K = round(2^32 / (N*M)), the result is floor((S*K + 2^15) / 2^16).
- R4: A scaled value above 65535 is saturated to 65535; for example, a stage of all-ones 1-bit samples gives 65535.
- R5: `stage_start` clears the sum and the count, even in the middle of a stage. A strobe in the same cycle as `stage_start` is not accumulated, and the abandoned stage yields no result.
- R6: Strobes before the first `stage_start` are ignored: no result is produced and `avg_out` is unchanged.
- R7: After the final sample of a stage, further strobes are ignored until the next `stage_start`: no extra valid pulse occurs and `avg_out` holds.
- R8: A change of `ratio_sel` during a stage does not alter that stage's length or scaling. It takes effect at the next `stage_start`.
- R9: `avg_valid` is high for exactly one cycle per completed stage, and `avg_out` changes only in the cycle `avg_valid` rises.
- R10: `avg_valid` and the new `avg_out` appear one clock edge after the edge that accepts the final sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_start | input | 1 | Clears the sum and count, samples `ratio_sel`, and starts a stage |
| ratio_sel | input | 2 | Decimation ratio code |
| smp_stb | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Modulator sample |
| avg_valid | output | 1 | One-cycle result pulse |
| avg_out | output | 16 | Scaled, rounded, saturated average |

## Verification
The final sample is accepted at a rising edge, and the result register loads at the next edge. The bench drives inputs on falling edges, so `avg_valid` must still be low at the falling edge after the last strobe and high at the following one. It checks both of those edges, then one more edge to confirm the pulse has ended. A pulse counter sampled at rising edges confirms exactly one pulse per stage, and no pulse during abandoned stages, stray strobes before a start, or strobes after a stage has completed.

// File: rtl/avg_pkg.sv
package avg_pkg;

  typedef enum logic [1:0] {
    SEL_X4  = 2'b00,
    SEL_X2  = 2'b01,
    SEL_X1  = 2'b10,
    SEL_X1B = 2'b11
  } ratio_code_e;

  // samples per stage for a selector code
  function automatic int stage_len(logic [1:0] code, int base, int mult);
    case (ratio_code_e'(code))
      SEL_X4:  return 4 * base * mult;
      SEL_X2:  return 2 * base * mult;
      default: return base * mult;
    endcase
  endfunction

  // rounded reciprocal: 2^sh / (n * maxs)
  function automatic longint unsigned recip_q(int n, int maxs, int sh);
    longint unsigned den;
    den = longint'(n) * longint'(maxs);
    return ((64'd1 << sh) + den / 2) / den;
  endfunction

endpackage

// File: rtl/dec_ratio_ctl.sv
module dec_ratio_ctl #(
  parameter int SAMPLE_W   = 1,
  parameter int BASE_RATIO = 64,
  parameter int OSR_MULT   = 3,
  parameter int RES_W      = 16,
  parameter int FRAC_W     = 16,
  parameter int CNT_W      = 10,
  parameter int K_W        = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] tgt_n,
  output logic [K_W-1:0]   tgt_k
);
  localparam int MAXS = (1 << SAMPLE_W) - 1;

  logic [CNT_W-1:0] lut_n [4];
  logic [K_W-1:0]   lut_k [4];

  for (genvar g = 0; g < 4; g++) begin : g_lut
    localparam int N = avg_pkg::stage_len(2'(g), BASE_RATIO, OSR_MULT);
    assign lut_n[g] = CNT_W'(N);
    assign lut_k[g] = K_W'(avg_pkg::recip_q(N, MAXS, RES_W + FRAC_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_n <= lut_n[0];
      tgt_k <= lut_k[0];
    end else if (start) begin
      tgt_n <= lut_n[sel];
      tgt_k <= lut_k[sel];
    end
  end

  // R8
  tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(tgt_n) && $stable(tgt_k)));

endmodule

// File: rtl/dec_accum.sv
module dec_accum #(
  parameter int SAMPLE_W = 1,
  parameter int CNT_W    = 10,
  parameter int SUM_W    = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                smp_stb,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic [CNT_W-1:0]    tgt,
  output logic [SUM_W-1:0]    acc,
  output logic                fin
);
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        acc    <= '0;
      end else if (active && smp_stb) begin
        acc <= acc + SUM_W'(smp);
        cnt <= cnt_nx;
        if (cnt_nx == tgt) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> $stable(acc));
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= tgt);
  // R9
  fin_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);

endmodule

// File: rtl/dec_scaler.sv
module dec_scaler #(
  parameter int SUM_W  = 10,
  parameter int K_W    = 32,
  parameter int RES_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fin,
  input  logic [SUM_W-1:0] acc,
  input  logic [K_W-1:0]   recip,
  output logic             res_vld,
  output logic [RES_W-1:0] res
);
  localparam int P_W = SUM_W + K_W;
  localparam int Q_W = P_W - FRAC_W;
  localparam logic [Q_W-1:0] RES_MAX = Q_W'((64'd1 << RES_W) - 1);

  logic [P_W-1:0]   prod;
  logic [Q_W-1:0]   q;
  logic [RES_W-1:0] sat;

  always_comb begin
    prod = P_W'(acc) * P_W'(recip) + P_W'(64'd1 << (FRAC_W - 1));
    q    = Q_W'(prod >> FRAC_W);
    sat  = (q > RES_MAX) ? RES_MAX[RES_W-1:0] : q[RES_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res     <= '0;
    end else begin
      res_vld <= fin;
      if (fin) res <= sat;
    end
  end

  // R9
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |=> !res_vld);
  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(res));
  // R10
  res_lat_chk: assert property (@(posedge clk) disable iff (rst)
    fin |=> res_vld);

endmodule

// File: rtl/dec_boxcar_avg.sv
module dec_boxcar_avg #(
  parameter int SAMPLE_W   = 1,
  parameter int BASE_RATIO = 64,
  parameter int OSR_MULT   = 3,
  parameter int RES_W      = 16,
  parameter int FRAC_W     = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stage_start,
  input  logic [1:0]          ratio_sel,
  input  logic                smp_stb,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                avg_valid,
  output logic [RES_W-1:0]    avg_out
);
  localparam int MAX_N = 4 * BASE_RATIO * OSR_MULT;
  localparam int CNT_W = $clog2(MAX_N + 1);
  localparam int SUM_W = $clog2(MAX_N * ((1 << SAMPLE_W) - 1) + 1);
  localparam int K_W   = RES_W + FRAC_W;

  logic [CNT_W-1:0] tgt_n;
  logic [K_W-1:0]   tgt_k;
  logic [SUM_W-1:0] acc;
  logic             fin;

  dec_ratio_ctl #(
    .SAMPLE_W(SAMPLE_W), .BASE_RATIO(BASE_RATIO), .OSR_MULT(OSR_MULT),
    .RES_W(RES_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W), .K_W(K_W)
  ) u_ratio (
    .clk(clk), .rst(rst), .start(stage_start), .sel(ratio_sel),
    .tgt_n(tgt_n), .tgt_k(tgt_k)
  );

  dec_accum #(
    .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .SUM_W(SUM_W)
  ) u_accum (
    .clk(clk), .rst(rst), .start(stage_start), .smp_stb(smp_stb),
    .smp(smp_data), .tgt(tgt_n), .acc(acc), .fin(fin)
  );

  dec_scaler #(
    .SUM_W(SUM_W), .K_W(K_W), .RES_W(RES_W), .FRAC_W(FRAC_W)
  ) u_scaler (
    .clk(clk), .rst(rst), .fin(fin), .acc(acc), .recip(tgt_k),
    .res_vld(avg_valid), .res(avg_out)
  );

endmodule

// File: tb/dec_boxcar_avg_bench.sv
module dec_boxcar_avg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stage_start = 1'b0;
  logic [1:0]  ratio_sel = 2'b00;
  logic        smp_stb = 1'b0;
  logic [0:0]  smp_data = 1'b0;
  logic        avg_valid;
  logic [15:0] avg_out;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always #5 clk = ~clk;

  dec_boxcar_avg u_dec_boxcar_avg (
    .clk(clk), .rst(rst), .stage_start(stage_start), .ratio_sel(ratio_sel),
    .smp_stb(smp_stb), .smp_data(smp_data),
    .avg_valid(avg_valid), .avg_out(avg_out)
  );

  always @(posedge clk) if (avg_valid) pulses++;

  // {sel, pattern, gap}
  localparam logic [5:0] VEC [8] = '{
    {2'b00, 2'd1, 2'd0}, {2'b01, 2'd2, 2'd1}, {2'b10, 2'd3, 2'd0},
    {2'b11, 2'd2, 2'd2}, {2'b00, 2'd3, 2'd1}, {2'b01, 2'd0, 2'd0},
    {2'b10, 2'd1, 2'd1}, {2'b11, 2'd0, 2'd0}
  };

  function automatic int len_of(logic [1:0] s);
    return (s == 2'b00) ? 768 : (s == 2'b01) ? 384 : 192;
  endfunction

  function automatic int exp_of(int ones, int n);
    longint k, q;
    k = ((64'd1 << 32) + n / 2) / n;
    q = (longint'(ones) * k + 32768) >>> 16;
    return (q > 65535) ? 65535 : int'(q);
  endfunction

  function automatic logic bit_of(int pat, int i);
    case (pat)
      0: return 1'b0;
      1: return 1'b1;
      2: return logic'(i % 2);
      default: return logic'(i % 3 == 0);
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic feed(int n, int pat, int gap, int i0, inout int ones);
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          smp_stb = 1'b0; smp_data = 1'b1;
          @(negedge clk);
        end
      end
      smp_stb = 1'b1;
      smp_data = bit_of(pat, i0 + i);
      if (smp_data == 1'b1) ones++;
      @(negedge clk);
    end
    smp_stb = 1'b0; smp_data = 1'b0;
  endtask

  task automatic expect_res(int exp_v, int p0, string tag);
    chk(avg_valid == 1'b0, {"R10 early ", tag}, int'(avg_valid), 0);
    @(negedge clk);
    chk(avg_valid == 1'b1, {"R10 due ", tag}, int'(avg_valid), 1);
    chk(avg_out == 16'(exp_v), {"R3 value ", tag}, int'(avg_out), exp_v);
    @(negedge clk);
    chk(avg_valid == 1'b0, {"R9 width ", tag}, int'(avg_valid), 0);
    chk(pulses - p0 == 1, {"R9 count ", tag}, pulses - p0, 1);
  endtask

  task automatic do_start(logic [1:0] s);
    stage_start = 1'b1; ratio_sel = s;
    @(negedge clk);
    stage_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ones, p0;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(avg_valid == 1'b0 && avg_out == 16'd0, "R1 in reset", int'(avg_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(avg_valid == 1'b0 && avg_out == 16'd0, "R1 after reset", int'(avg_out), 0);

    // R6: strobes without any start
    ones = 0;
    feed(800, 1, 0, 0, ones);
    repeat (3) @(negedge clk);
    chk(pulses == 0, "R6 no pulse", pulses, 0);
    chk(avg_out == 16'd0, "R6 output held", int'(avg_out), 0);

    // table walk: R2 lengths, R3 scaling, R4 saturation
    for (int v = 0; v < 8; v++) begin
      logic [1:0] s;
      int n;
      s = VEC[v][5:4];
      n = len_of(s);
      ones = 0;
      do_start(s);
      p0 = pulses;
      feed(n, int'(VEC[v][3:2]), int'(VEC[v][1:0]), 0, ones);
      expect_res(exp_of(ones, n), p0, $sformatf("R2 R4 vec%0d", v));
    end

    // R7: strobes after completion ignored
    ones = 0;
    do_start(2'b10);
    p0 = pulses;
    feed(192, 1, 0, 0, ones);
    expect_res(65535, p0, "R4 full");
    p0 = pulses;
    ones = 0;
    feed(300, 1, 0, 0, ones);
    repeat (3) @(negedge clk);
    chk(pulses == p0, "R7 no extra pulse", pulses - p0, 0);
    chk(avg_out == 16'd65535, "R7 output held", int'(avg_out), 65535);

    // R5: restart mid-stage, strobe during start dropped
    ones = 0;
    do_start(2'b10);
    p0 = pulses;
    feed(100, 1, 0, 0, ones);
    stage_start = 1'b1; smp_stb = 1'b1; smp_data = 1'b1;
    @(negedge clk);
    stage_start = 1'b0; smp_stb = 1'b0;
    ones = 0;
    feed(192, 0, 0, 0, ones);
    expect_res(0, p0, "R5 restart");

    // R8: selector change mid-stage has no effect
    ones = 0;
    do_start(2'b10);
    p0 = pulses;
    feed(10, 2, 0, 0, ones);
    ratio_sel = 2'b00;
    feed(182, 2, 0, 10, ones);
    expect_res(exp_of(ones, 192), p0, "R8 late change");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule